// File: doc/BRIEF.md
# Subnet Change Request Controller

This block sits beside each router of a power-gated, non-zero subnet in a multi-subnet mesh. Control packets arriving on the four mesh input ports may ask to leave the upper subnet and be re-injected into the always-on subnet 0 through the node's network interface. That way they avoid waking further gated routers on their path. Data packets never ask, because they are long and would hold the interface busy for many cycles.

Each cycle the controller looks at the requests raised in the first pipeline stage. It picks the one whose packet still has the most hops to travel and sends it to the interface, but only when no request went out in either of the two previous cycles. This spacing ensures that a grant, which comes back two cycles after its request, can only belong to one packet. On a grant, the flit moves into a bypass buffer and leaves toward the interface in the fourth stage, and its crossbar slot is cancelled. The normal pipeline (route computation, VC allocation, switch allocation, crossbar) is modelled as a fixed timeline. A crossbar flit and a bypassed flit can free slots of the same input buffer in one cycle, so credits are returned as a small count per port.

Top module: `subnet_xchg_ctrl`

## Requirements
- R1: Only a valid flit with the control bit set (`in_ctrl`=1) is a candidate; data flits never cause `ni_req`, and `ni_req` is driven combinationally in the same cycle the flit is presented (first stage).
- R2: Among candidates the largest `in_hops` wins; equal counts go to the lowest port index, with port 0 = north, 1 = east, 2 = south, 3 = west. The winner's port and VC appear on `byp_port`/`byp_vc` when its bypass departs.
- R3: `ni_req` is never high if it was high in either of the two preceding cycles. A candidate blocked by this rule is dropped and its flit stays on the crossbar path.
- R4: When `ni_gnt` is high exactly two cycles after a cycle with `ni_req`, `byp_vld` is high in the next cycle, with the port and VC latched when the request went out.
- R5: `ni_gnt` in a cycle that is not two cycles after a request has no effect: no bypass departure and no bypass credit.
- R6: A valid flit presented on port p in cycle c raises `xbar_go[p]` in cycle c+3, unless it was granted, in which case `xbar_go[p]` stays low in that cycle.
- R7: `cr_cnt` holds, per port, a count of the flits freed that cycle: one for a crossbar departure (`xbar_go`) plus one for a grant landing on that port. The value may be 2. Port p occupies bits [2p+1:2p] with the default depth.
- R8: While `rst_n` is low, all registered outputs are zero, and a reset clears any outstanding request and the spacing window.
- R9: A flit whose packet has already changed subnet once (`in_moved`=1) never raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 4 | Flit present in stage 1, one bit per port (0=N,1=E,2=S,3=W) |
| in_ctrl | input | 4 | Flit belongs to a control packet |
| in_moved | input | 4 | Packet has already changed subnet |
| in_hops | input | 16 | Remaining hop count, 4 bits per port |
| in_vc | input | 8 | Input VC number, 2 bits per port |
| ni_req | output | 1 | Subnet-change request to the network interface |
| ni_gnt | input | 1 | Grant from the interface, two cycles after a request |
| byp_vld | output | 1 | Granted flit leaves through the bypass buffer |
| byp_port | output | 2 | Input port of the bypassed flit |
| byp_vc | output | 2 | VC of the bypassed flit |
| xbar_go | output | 4 | Flit of that port traverses the crossbar (stage 4) |
| cr_cnt | output | 8 | Credits returned per port, 2 bits per port |

## Verification
The hardest case to reach is a credit count of two: a bypass grant has to land on a port in the same cycle that an older, ungranted flit from that port reaches the crossbar stage. The vector table places a data flit on the north port three cycles before a north request's grant returns, so both departures coincide. It also interleaves blocked requests, a denied grant, a stray grant and a reset taken while a grant is outstanding. Together these show that the spacing window and the pending-request tracking never pair a grant with the wrong flit.

// File: rtl/scx_pkg.sv
package scx_pkg;
  // Mesh input ports handled by one controller, in tie-break order.
  localparam int NUM_PORTS = 4;
  localparam int PORT_W    = $clog2(NUM_PORTS);
  // Cycles from a request to its grant; also the request spacing window.
  localparam int GNT_LAT   = 2;
  // Port indices: north, east, south, west.
  localparam logic [PORT_W-1:0] DIR_N = 2'd0;
  localparam logic [PORT_W-1:0] DIR_E = 2'd1;
  localparam logic [PORT_W-1:0] DIR_S = 2'd2;
  localparam logic [PORT_W-1:0] DIR_W = 2'd3;
endpackage

// File: rtl/scx_hop_arb.sv
module scx_hop_arb
  import scx_pkg::*;
#(
  parameter int HOP_W = 4,
  parameter int VC_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS-1:0]       elig,
  input  logic [NUM_PORTS*HOP_W-1:0] hops,
  input  logic [NUM_PORTS*VC_W-1:0]  vcs,
  output logic                       any,
  output logic [PORT_W-1:0]          win,
  output logic [VC_W-1:0]            win_vc
);

  logic [HOP_W-1:0] best_hops;

  // Scan in port order; strict compare keeps the earlier port on a tie.
  always_comb begin
    any       = 1'b0;
    win       = '0;
    best_hops = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (elig[i] && (!any || (hops[i*HOP_W +: HOP_W] > best_hops))) begin
        any       = 1'b1;
        win       = PORT_W'(i);
        best_hops = hops[i*HOP_W +: HOP_W];
      end
    end
  end

  assign win_vc = vcs[win*VC_W +: VC_W];

  logic [HOP_W-1:0] win_hops_chk;
  assign win_hops_chk = hops[win*HOP_W +: HOP_W];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_arb_chk
    AST_NO_LONGER_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
      (any && elig[p]) |-> (hops[p*HOP_W +: HOP_W] <= win_hops_chk)); // R2
    AST_TIE_LOW_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      (any && elig[p] && (hops[p*HOP_W +: HOP_W] == win_hops_chk)) |-> (win <= PORT_W'(p))); // R2
  end

endmodule

// File: rtl/scx_req_pacer.sv
module scx_req_pacer
  import scx_pkg::*;
#(
  parameter int VC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand,
  input  logic [PORT_W-1:0] cand_port,
  input  logic [VC_W-1:0]   cand_vc,
  input  logic              ni_gnt,
  output logic              ni_req,
  output logic              land,
  output logic [PORT_W-1:0] land_port,
  output logic              byp_vld,
  output logic [PORT_W-1:0] byp_port,
  output logic [VC_W-1:0]   byp_vc
);

  localparam int HOLD_W = $clog2(GNT_LAT + 1);

  logic [HOLD_W-1:0]  hold_q, hold_d;
  logic [GNT_LAT-1:0] pend_q, pend_d;
  logic [PORT_W-1:0]  lat_port_q;
  logic [VC_W-1:0]    lat_vc_q;
  logic               byp_vld_q, byp_vld_d;
  logic [PORT_W-1:0]  byp_port_q;
  logic [VC_W-1:0]    byp_vc_q;

  // Forward only when the spacing window has drained.
  assign ni_req    = cand && (hold_q == '0);
  // A grant counts only when it lines up with the outstanding request.
  assign land      = pend_q[GNT_LAT-1] && ni_gnt;
  assign land_port = lat_port_q;

  always_comb begin
    if (ni_req)
      hold_d = HOLD_W'(GNT_LAT);
    else if (hold_q != '0)
      hold_d = hold_q - 1'b1;
    else
      hold_d = hold_q;
    pend_d    = {pend_q[GNT_LAT-2:0], ni_req};
    byp_vld_d = land;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      pend_q    <= '0;
      byp_vld_q <= 1'b0;
    end else begin
      hold_q    <= hold_d;
      pend_q    <= pend_d;
      byp_vld_q <= byp_vld_d;
    end
  end

  // Winner identity, captured when the request leaves.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_port_q <= '0;
      lat_vc_q   <= '0;
    end else if (ni_req) begin
      lat_port_q <= cand_port;
      lat_vc_q   <= cand_vc;
    end
  end

  // Bypass departure tag, loaded when a grant lands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_port_q <= '0;
      byp_vc_q   <= '0;
    end else if (land) begin
      byp_port_q <= lat_port_q;
      byp_vc_q   <= lat_vc_q;
    end
  end

  assign byp_vld  = byp_vld_q;
  assign byp_port = byp_port_q;
  assign byp_vc   = byp_vc_q;

  AST_REQ_GAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ni_req |=> !ni_req); // R3
  AST_REQ_GAP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    ni_req |=> ##1 !ni_req); // R3
  AST_BYP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    byp_vld |-> $past(ni_req, GNT_LAT + 1)); // R4
  AST_STRAY_GNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ni_gnt && !pend_q[GNT_LAT-1]) |=> !byp_vld); // R5

endmodule

// File: rtl/scx_xbar_pipe.sv
module scx_xbar_pipe
  import scx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] in_vld,
  input  logic                 kill,
  input  logic [PORT_W-1:0]    kill_port,
  output logic [NUM_PORTS-1:0] xbar_go
);

  // Stages 2 and 3 (VC and switch allocation) are pure delay here;
  // the crossbar slot is dropped when a grant lands in stage 3.
  localparam int MID = GNT_LAT;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [MID-1:0] sh_q, sh_d;
    logic           go_q, go_d;

    always_comb begin
      sh_d = {sh_q[MID-2:0], in_vld[p]};
      go_d = sh_q[MID-1] && !(kill && (kill_port == PORT_W'(p)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '0;
        go_q <= 1'b0;
      end else begin
        sh_q <= sh_d;
        go_q <= go_d;
      end
    end

    assign xbar_go[p] = go_q;

    AST_XBAR_FROM_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
      xbar_go[p] |-> $past(in_vld[p], MID + 1)); // R6
  end

endmodule

// File: rtl/subnet_xchg_ctrl.sv
module subnet_xchg_ctrl
  import scx_pkg::*;
#(
  parameter int  SUBNET_ID = 1,
  parameter int  HOP_W     = 4,
  parameter int  VC_W      = 2,
  parameter int  BUF_DEPTH = 4,
  localparam int CW        = (BUF_DEPTH >= 4) ? $clog2(BUF_DEPTH) : 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS-1:0]       in_vld,
  input  logic [NUM_PORTS-1:0]       in_ctrl,
  input  logic [NUM_PORTS-1:0]       in_moved,
  input  logic [NUM_PORTS*HOP_W-1:0] in_hops,
  input  logic [NUM_PORTS*VC_W-1:0]  in_vc,
  output logic                       ni_req,
  input  logic                       ni_gnt,
  output logic                       byp_vld,
  output logic [PORT_W-1:0]          byp_port,
  output logic [VC_W-1:0]            byp_vc,
  output logic [NUM_PORTS-1:0]       xbar_go,
  output logic [NUM_PORTS*CW-1:0]    cr_cnt
);

  logic [NUM_PORTS-1:0] elig;
  logic                 cand;
  logic [PORT_W-1:0]    cand_port;
  logic [VC_W-1:0]      cand_vc;
  logic                 land;
  logic [PORT_W-1:0]    land_port;

  // Subnet 0 is the destination of every move, so its routers never ask.
  if (SUBNET_ID == 0) begin : g_base_subnet
    assign elig = '0;
  end else begin : g_upper_subnet
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_elig
      assign elig[p] = in_vld[p] && in_ctrl[p] && !in_moved[p];
    end
  end

  scx_hop_arb #(
    .HOP_W (HOP_W),
    .VC_W  (VC_W)
  ) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .elig   (elig),
    .hops   (in_hops),
    .vcs    (in_vc),
    .any    (cand),
    .win    (cand_port),
    .win_vc (cand_vc)
  );

  scx_req_pacer #(
    .VC_W (VC_W)
  ) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand      (cand),
    .cand_port (cand_port),
    .cand_vc   (cand_vc),
    .ni_gnt    (ni_gnt),
    .ni_req    (ni_req),
    .land      (land),
    .land_port (land_port),
    .byp_vld   (byp_vld),
    .byp_port  (byp_port),
    .byp_vc    (byp_vc)
  );

  scx_xbar_pipe u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .kill      (land),
    .kill_port (land_port),
    .xbar_go   (xbar_go)
  );

  // A flit moving into the bypass buffer and an older flit crossing the
  // switch can both free a slot of the same input buffer this cycle.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_credit
    logic byp_free;
    assign byp_free = land && (land_port == PORT_W'(p));
    assign cr_cnt[p*CW +: CW] = CW'(xbar_go[p]) + CW'(byp_free);
  end

  AST_REQ_FROM_CONTROL: assert property (@(posedge clk) disable iff (!rst_n)
    ni_req |-> (in_vld[cand_port] && in_ctrl[cand_port] && !in_moved[cand_port])); // R1
  AST_BYP_NOT_XBAR: assert property (@(posedge clk) disable iff (!rst_n)
    byp_vld |-> !xbar_go[byp_port]); // R6

endmodule

// File: tb/subnet_xchg_ctrl_tb.sv
module subnet_xchg_ctrl_tb;

  typedef struct packed {
    logic [3:0]  vld;
    logic [3:0]  ctrl;
    logic [3:0]  mov;
    logic [15:0] hops;
    logic [7:0]  vc;
    logic        gnt;
    logic        e_req;
    logic        e_bv;
    logic [1:0]  e_bp;
    logic [1:0]  e_bvc;
    logic [3:0]  e_xb;
    logic [7:0]  e_cr;
  } vec_t;

  // Per-port fields: port 0 (north) in the lowest slice.
  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{4'b1110, 4'b0110, 4'b0000, 16'h9750, 8'h18, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 4'b0000, 8'h00},
    '{4'b0001, 4'b0001, 4'b0000, 16'h0003, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'b0000, 8'h00},
    '{4'b0001, 4'b0000, 4'b0000, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'b0000, 8'h10},
    '{4'b0001, 4'b0001, 4'b0000, 16'h0002, 8'h03, 1'b0, 1'b1, 1'b1, 2'd2, 2'd1, 4'b1010, 8'h44},
    '{4'b0110, 4'b0110, 4'b0000, 16'h0440, 8'h00, 1'b0, 1'b0, 1'b0, 2'd2, 2'd1, 4'b0001, 8'h01},
    '{4'b0000, 4'b0000, 4'b0000, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 2'd2, 2'd1, 4'b0001, 8'h02},
    '{4'b1001, 4'b1001, 4'b0000, 16'h6006, 8'hC0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd3, 4'b0000, 8'h00},
    '{4'b0000, 4'b0000, 4'b0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 4'b0110, 8'h14},
    '{4'b0000, 4'b0000, 4'b0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 4'b0000, 8'h00},
    '{4'b0110, 4'b0010, 4'b0010, 16'h0080, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 4'b1001, 8'h41},
    '{4'b1000, 4'b1000, 4'b0000, 16'h1000, 8'h80, 1'b0, 1'b1, 1'b0, 2'd0, 2'd3, 4'b0000, 8'h00},
    '{4'b0000, 4'b0000, 4'b0000, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 4'b0000, 8'h00},
    '{4'b0000, 4'b0000, 4'b0000, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 4'b0110, 8'h54},
    '{4'b0000, 4'b0000, 4'b0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 2'd3, 2'd2, 4'b0000, 8'h00}
  };

  logic        clk;
  logic        rst_n;
  logic [3:0]  in_vld, in_ctrl, in_moved;
  logic [15:0] in_hops;
  logic [7:0]  in_vc;
  logic        ni_req, ni_gnt, byp_vld;
  logic [1:0]  byp_port, byp_vc;
  logic [3:0]  xbar_go;
  logic [7:0]  cr_cnt;

  int checks = 0;
  int errors = 0;

  subnet_xchg_ctrl u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_ctrl  (in_ctrl),
    .in_moved (in_moved),
    .in_hops  (in_hops),
    .in_vc    (in_vc),
    .ni_req   (ni_req),
    .ni_gnt   (ni_gnt),
    .byp_vld  (byp_vld),
    .byp_port (byp_port),
    .byp_vc   (byp_vc),
    .xbar_go  (xbar_go),
    .cr_cnt   (cr_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v, input logic [3:0] c, input logic [3:0] m,
                       input logic [15:0] h, input logic [7:0] vc, input logic g);
    in_vld   = v;
    in_ctrl  = c;
    in_moved = m;
    in_hops  = h;
    in_vc    = vc;
    ni_gnt   = g;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(4'h0, 4'h0, 4'h0, 16'h0, 8'h0, 1'b0);
    repeat (3) @(negedge clk);
    #2;
    chk("R8", "reset byp_vld", 32'(byp_vld), 32'd0);
    chk("R8", "reset xbar_go", 32'(xbar_go), 32'd0);
    chk("R8", "reset cr_cnt", 32'(cr_cnt), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table: one row per cycle, outputs sampled before the next edge.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i].vld, TBL[i].ctrl, TBL[i].mov, TBL[i].hops, TBL[i].vc, TBL[i].gnt);
      #2;
      chk("R3", $sformatf("row %0d ni_req", i), 32'(ni_req), 32'(TBL[i].e_req));
      chk("R4", $sformatf("row %0d byp_vld", i), 32'(byp_vld), 32'(TBL[i].e_bv));
      if (TBL[i].e_bv) begin
        chk("R4", $sformatf("row %0d byp_port", i), 32'(byp_port), 32'(TBL[i].e_bp));
        chk("R4", $sformatf("row %0d byp_vc", i), 32'(byp_vc), 32'(TBL[i].e_bvc));
      end
      chk("R6", $sformatf("row %0d xbar_go", i), 32'(xbar_go), 32'(TBL[i].e_xb));
      chk("R7", $sformatf("row %0d cr_cnt", i), 32'(cr_cnt), 32'(TBL[i].e_cr));
    end

    // R1: data flits on every port never request.
    @(negedge clk);
    drive(4'b1111, 4'b0000, 4'b0000, 16'hFFFF, 8'hFF, 1'b0);
    #2 chk("R1", "data-only ni_req", 32'(ni_req), 32'd0);

    // R9: a control flit already moved once does not request.
    @(negedge clk);
    drive(4'b0001, 4'b0001, 4'b0001, 16'h000F, 8'h00, 1'b0);
    #2 chk("R9", "moved flit ni_req", 32'(ni_req), 32'd0);

    // R2: E and W tie at 15 above N at 14; east wins.
    @(negedge clk);
    drive(4'b1011, 4'b1011, 4'b0000, 16'hF0FE, 8'hC6, 1'b0);
    #2 chk("R2", "priority ni_req", 32'(ni_req), 32'd1);
    @(negedge clk);
    drive(4'h0, 4'h0, 4'h0, 16'h0, 8'h0, 1'b0);
    @(negedge clk);
    drive(4'h0, 4'h0, 4'h0, 16'h0, 8'h0, 1'b1);
    #2 chk("R7", "east bypass credit", 32'(cr_cnt[3:2]), 32'd1);
    @(negedge clk);
    drive(4'b0100, 4'b0100, 4'b0000, 16'h0300, 8'h20, 1'b0);
    #2;
    chk("R2", "tie winner port", 32'(byp_port), 32'd1);
    chk("R2", "tie winner vc", 32'(byp_vc), 32'd1);
    chk("R3", "request after window", 32'(ni_req), 32'd1);

    // R8: reset with a request outstanding.
    @(negedge clk);
    drive(4'h0, 4'h0, 4'h0, 16'h0, 8'h0, 1'b0);
    rst_n = 1'b0;
    #2;
    chk("R8", "mid-run reset byp_vld", 32'(byp_vld), 32'd0);
    chk("R8", "mid-run reset xbar_go", 32'(xbar_go), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(4'h0, 4'h0, 4'h0, 16'h0, 8'h0, 1'b1);
    #2 chk("R5", "stale grant credit", 32'(cr_cnt), 32'd0);
    @(negedge clk);
    drive(4'b0001, 4'b0001, 4'b0000, 16'h0001, 8'h00, 1'b0);
    #2;
    chk("R5", "stale grant byp_vld", 32'(byp_vld), 32'd0);
    chk("R8", "window cleared by reset", 32'(ni_req), 32'd1);

    @(negedge clk);
    drive(4'h0, 4'h0, 4'h0, 16'h0, 8'h0, 1'b0);
    finish_run();
  end

endmodule